// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frame bytes into memory buffers. Software sets up a circular chain of descriptors in memory. Each descriptor names one buffer and the descriptor that follows it. The engine takes a byte stream with an end-of-frame marker and per-frame error flags. It packs the bytes into 32-bit words and writes them to the buffer of the current descriptor. When a frame does not fit in one buffer, the engine continues it in the next descriptor. Once a descriptor is finished, the engine writes its status word back and hands the descriptor to software.

The MAC side cannot be stalled, so incoming bytes first enter a small FIFO. The FIFO absorbs descriptor fetches and pauses while no descriptor is available. When the FIFO fills, the rest of that frame is discarded and the loss is recorded in the frame's closing descriptor. Start, stop and resume are single-cycle command pulses. Frame completion, overflow and stop are reported as one-cycle event pulses. Buffer-unavailable is a level that stays high while the engine waits for a resume command.

Top module: `rxd_ring_dma`

## Requirements
- R1: After reset the engine is stopped, no memory access is made and all four event outputs are low.
- R2: A descriptor is four words at consecutive byte addresses, starting from `ring_base` after a start command. Word 0 is status, with bit 31 meaning hardware owns the descriptor. Word 1 holds the buffer size in bytes in bits 12:0. Word 2 holds the buffer byte address and word 3 holds the next descriptor address. The engine only uses descriptors with bit 31 set.
- R3: Bytes are packed little-endian: the first byte of a word goes in bits 7:0. A partial final word is written with only its valid byte lanes enabled, so the other lanes of that memory word keep their old value.
- R4: A frame that fits one buffer gets a status word with bit 31 = 0, bit 9 (first segment) = 1, bit 8 (last segment) = 1 and the byte count in bits 29:16. One frame-complete pulse follows that write.
- R5: A frame longer than its buffer continues in the next descriptors. The opening descriptor has only bit 9 set, middle descriptors have neither bit 9 nor bit 8, and the closing descriptor has bit 8 set and holds the total frame length. Bits 29:16 are 0 in every descriptor except the closing one.
- R6: In the closing descriptor, bit 1 reports the CRC error flag and bit 12 the length error flag given with the frame's last byte. Bit 15 is set whenever bit 1, 11 or 12 is set.
- R7: When the descriptor to be used has bit 31 clear, the engine makes no further progress and holds `ev_buf_unavail` high. A resume command makes it read that same descriptor again.
- R8: If a byte arrives while the FIFO is full, that byte and the rest of its frame are discarded and `ev_overflow` pulses. The closing descriptor gets bits 11 and 15 set, and its length counts only the bytes that were stored.
- R9: If a buffer fills mid-frame and the next descriptor is not owned by hardware, the current descriptor is closed with bits 8, 11 and 15 set and the length stored so far. The engine then pulses `ev_overflow` and frame-complete, discards the remainder of the frame and raises `ev_buf_unavail`.
- R10: A stop command takes effect at a descriptor boundary, while paused, or while waiting between frames, and produces one `ev_stopped` pulse. While the engine is stopped, input bytes are ignored and the descriptors are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | AW | First descriptor address, taken on start |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Stop pulse |
| cmd_resume | input | 1 | Resume pulse after a pause |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_crc_err | input | 1 | Frame CRC error, valid with in_last |
| in_len_err | input | 1 | Frame length error, valid with in_last |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| ev_frame_done | output | 1 | Pulse after a closing descriptor is written |
| ev_buf_unavail | output | 1 | High while paused for lack of a descriptor |
| ev_overflow | output | 1 | Pulse on lost data |
| ev_stopped | output | 1 | Pulse on entering the stopped state |

## Verification
Fetching a descriptor takes five cycles: a request followed by four read-data captures. Each stored byte then takes one cycle, the status writeback takes one more, and a frame-complete pulse appears in the cycle after that write. An overflow pulse comes one cycle after the lost byte. The buffer-unavailable level rises two cycles after the status word is requested. The bench waits a settle window well longer than the worst-case path for each scenario before it reads memory and the event counters. It samples the level output on falling edges, and it checks that the level is still held many cycles later, so that no check depends on an exact edge.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int OWN_B  = 31;
  localparam int ES_B   = 15;
  localparam int LERR_B = 12;
  localparam int OVF_B  = 11;
  localparam int FS_B   = 9;
  localparam int LS_B   = 8;
  localparam int CRC_B  = 1;
  localparam int FL_LSB = 16;
  localparam int FL_W   = 14;
  localparam int SZ_W   = 13;

  typedef struct packed {
    logic       mark;
    logic       lerr;
    logic       crc;
    logic       last;
    logic [7:0] data;
  } ent_t;

  typedef enum logic [3:0] {
    S_IDLE, S_F0, S_F1, S_F2, S_F3, S_F4, S_FILL,
    S_P0, S_P1, S_WB, S_DISC, S_SUSP
  } st_t;
endpackage

// File: rtl/rxd_infifo.sv
module rxd_infifo
  import rxd_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_crc,
  input  logic       in_lerr,
  input  logic       pop,
  output ent_t       out_ent,
  output logic       out_valid,
  output logic       ovf_pulse
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

  ent_t           mem_q [DEPTH];
  logic [AW-1:0]  wp_q, rp_q;
  logic [AW:0]    cnt_q, cnt_d;
  logic           drop_q, drop_d, term_q, term_d;
  logic           full, term_push, data_push, push, do_pop;
  ent_t           wr_ent;

  assign full      = (cnt_q == FULLV);
  assign out_valid = (cnt_q != '0);
  assign out_ent   = mem_q[rp_q];
  assign do_pop    = pop & out_valid;
  assign term_push = term_q & ~full;
  assign data_push = in_valid & en & ~drop_q & ~term_q & ~full;
  assign push      = term_push | data_push;

  always_comb begin
    wr_ent = term_push ? '{mark: 1'b1, lerr: 1'b0, crc: 1'b0, last: 1'b1, data: 8'h00}
                       : '{mark: 1'b0, lerr: in_lerr, crc: in_crc, last: in_last, data: in_data};
    cnt_d  = cnt_q + (AW+1)'(push) - (AW+1)'(do_pop);
    drop_d = drop_q;
    term_d = term_q;
    ovf_pulse = 1'b0;
    if (term_push) term_d = 1'b0;
    if (in_valid && en && !data_push) begin
      if (drop_q) begin
        if (in_last) begin
          drop_d = 1'b0;
          term_d = 1'b1;
        end
      end else begin
        ovf_pulse = 1'b1;
        if (in_last) term_d = 1'b1;
        else         drop_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      drop_q <= 1'b0;
      term_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      drop_q <= drop_d;
      term_q <= term_d;
      if (push)   wp_q <= wp_q + 1'b1;
      if (do_pop) rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= wr_ent;
  end

  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULLV);
  assert_marker_needs_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_q) |-> $past(in_valid));
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
  import rxd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cmd_resume,
  input  ent_t          f_ent,
  input  logic          f_valid,
  output logic          f_pop,
  input  logic          in_ovf,
  output logic          rx_en,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic [31:0]   mem_rdata,
  output logic          ev_frame_done,
  output logic          ev_buf_unavail,
  output logic          ev_overflow,
  output logic          ev_stopped
);
  st_t             st_q, st_d;
  logic [AW-1:0]   cur_q, cur_d, nxt_q, nxt_d, bufa_q, bufa_d;
  logic [SZ_W-1:0] bsz_q, bsz_d, bcnt_q, bcnt_d, bcnt_inc;
  logic [FL_W-1:0] flen_q, flen_d;
  logic [31:0]     wbuf_q, wbuf_d, wb_word;
  logic            first_q, first_d, ls_q, ls_d, ovf_q, ovf_d;
  logic            crc_q, crc_d, lerr_q, lerr_d, trunc_q, trunc_d;
  logic            stop_q, stop_d, fev_q, fev_d, oev_q, oev_d, sev_q, sev_d;
  logic [1:0]      lane;
  logic [AW-1:0]   waddr;
  logic [31:0]     unused_rd;

  assign unused_rd = mem_rdata;
  assign lane      = bcnt_q[1:0];
  assign bcnt_inc  = bcnt_q + 1'b1;
  assign waddr     = bufa_q + {{(AW-SZ_W){1'b0}}, bcnt_q[SZ_W-1:2], 2'b00};
  assign rx_en     = (st_q != S_IDLE);

  always_comb begin
    wb_word = '0;
    wb_word[FS_B]   = first_q;
    wb_word[LS_B]   = ls_q;
    wb_word[CRC_B]  = crc_q;
    wb_word[OVF_B]  = ovf_q;
    wb_word[LERR_B] = lerr_q;
    wb_word[ES_B]   = ls_q & (crc_q | ovf_q | lerr_q);
    wb_word[FL_LSB +: FL_W] = ls_q ? flen_q : '0;
  end

  always_comb begin
    st_d = st_q; cur_d = cur_q; nxt_d = nxt_q; bufa_d = bufa_q;
    bsz_d = bsz_q; bcnt_d = bcnt_q; flen_d = flen_q; wbuf_d = wbuf_q;
    first_d = first_q; ls_d = ls_q; ovf_d = ovf_q; crc_d = crc_q;
    lerr_d = lerr_q; trunc_d = trunc_q;
    stop_d = stop_q | cmd_stop;
    fev_d = 1'b0; sev_d = 1'b0; oev_d = in_ovf;
    mem_en = 1'b0; mem_we = 1'b0; mem_addr = cur_q; mem_wdata = '0; mem_be = '0;
    f_pop = 1'b0;
    case (st_q)
      S_IDLE: begin
        stop_d = 1'b0;
        if (cmd_start) begin
          cur_d = ring_base; first_d = 1'b1; flen_d = '0; st_d = S_F0;
        end
      end
      S_F0: begin
        if (stop_q) begin
          st_d = S_IDLE; sev_d = 1'b1;
        end else begin
          mem_en = 1'b1; st_d = S_F1;
        end
      end
      S_F1: begin
        if (!mem_rdata[OWN_B]) st_d = S_SUSP;
        else begin
          mem_en = 1'b1; mem_addr = cur_q + AW'(4); st_d = S_F2;
        end
      end
      S_F2: begin
        bsz_d = mem_rdata[SZ_W-1:0];
        mem_en = 1'b1; mem_addr = cur_q + AW'(8); st_d = S_F3;
      end
      S_F3: begin
        bufa_d = mem_rdata[AW-1:0];
        mem_en = 1'b1; mem_addr = cur_q + AW'(12); st_d = S_F4;
      end
      S_F4: begin
        nxt_d = mem_rdata[AW-1:0]; bcnt_d = '0; st_d = S_FILL;
      end
      S_FILL: begin
        mem_addr = waddr;
        if (f_valid) begin
          f_pop = 1'b1;
          if (f_ent.mark) begin
            if (lane != 2'd0) begin
              mem_en = 1'b1; mem_we = 1'b1; mem_wdata = wbuf_q;
              mem_be = 4'((5'd1 << lane) - 5'd1);
            end
            ls_d = 1'b1; ovf_d = 1'b1; crc_d = 1'b0; lerr_d = 1'b0; st_d = S_WB;
          end else begin
            wbuf_d[{lane, 3'b000} +: 8] = f_ent.data;
            bcnt_d = bcnt_inc;
            flen_d = flen_q + 1'b1;
            if (lane == 2'd3 || f_ent.last || bcnt_inc == bsz_q) begin
              mem_en = 1'b1; mem_we = 1'b1; mem_wdata = wbuf_d;
              mem_be = 4'((5'd2 << lane) - 5'd1);
            end
            if (f_ent.last) begin
              ls_d = 1'b1; ovf_d = 1'b0; crc_d = f_ent.crc; lerr_d = f_ent.lerr;
              st_d = S_WB;
            end else if (bcnt_inc == bsz_q) begin
              st_d = S_P0;
            end
          end
        end else if (stop_q && bcnt_q == '0 && flen_q == '0) begin
          st_d = S_IDLE; sev_d = 1'b1;
        end
      end
      S_P0: begin
        mem_en = 1'b1; mem_addr = nxt_q; st_d = S_P1;
      end
      S_P1: begin
        crc_d = 1'b0; lerr_d = 1'b0; st_d = S_WB;
        if (mem_rdata[OWN_B]) begin
          ls_d = 1'b0; ovf_d = 1'b0;
        end else begin
          ls_d = 1'b1; ovf_d = 1'b1; trunc_d = 1'b1;
        end
      end
      S_WB: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_be = 4'hF; mem_wdata = wb_word;
        cur_d = nxt_q;
        if (ls_q) begin
          fev_d = 1'b1; flen_d = '0; first_d = 1'b1;
        end else begin
          first_d = 1'b0;
        end
        if (trunc_q) begin
          oev_d = 1'b1; trunc_d = 1'b0; st_d = S_DISC;
        end else begin
          st_d = S_F0;
        end
      end
      S_DISC: begin
        if (f_valid) begin
          f_pop = 1'b1;
          if (f_ent.last) st_d = S_F0;
        end
      end
      S_SUSP: begin
        if (stop_q) begin
          st_d = S_IDLE; sev_d = 1'b1;
        end else if (cmd_resume) begin
          st_d = S_F0;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cur_q <= '0; nxt_q <= '0; bufa_q <= '0; bsz_q <= '0;
      bcnt_q <= '0; flen_q <= '0; wbuf_q <= '0; first_q <= 1'b1; ls_q <= 1'b0;
      ovf_q <= 1'b0; crc_q <= 1'b0; lerr_q <= 1'b0; trunc_q <= 1'b0;
      stop_q <= 1'b0; fev_q <= 1'b0; oev_q <= 1'b0; sev_q <= 1'b0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; nxt_q <= nxt_d; bufa_q <= bufa_d; bsz_q <= bsz_d;
      bcnt_q <= bcnt_d; flen_q <= flen_d; wbuf_q <= wbuf_d; first_q <= first_d;
      ls_q <= ls_d; ovf_q <= ovf_d; crc_q <= crc_d; lerr_q <= lerr_d;
      trunc_q <= trunc_d; stop_q <= stop_d; fev_q <= fev_d; oev_q <= oev_d;
      sev_q <= sev_d;
    end
  end

  assign ev_frame_done  = fev_q;
  assign ev_overflow    = oev_q;
  assign ev_stopped     = sev_q;
  assign ev_buf_unavail = (st_q == S_SUSP);

  assert_wait_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_buf_unavail && !cmd_resume && !cmd_stop && !stop_q) |=> ev_buf_unavail);
  assert_done_after_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |-> ($past(mem_we) && $past(mem_wdata[LS_B]) && !$past(mem_wdata[OWN_B])));
  assert_lanes_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be != 4'h0));
  assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stopped |-> (!rx_en && !mem_en));
endmodule

// File: rtl/rxd_ring_dma.sv
module rxd_ring_dma
  import rxd_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cmd_resume,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_crc_err,
  input  logic          in_len_err,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic [31:0]   mem_rdata,
  output logic          ev_frame_done,
  output logic          ev_buf_unavail,
  output logic          ev_overflow,
  output logic          ev_stopped
);
  logic [1:0] rsync_q;
  logic       rst_i;
  ent_t       f_ent;
  logic       f_valid, f_pop, in_ovf, rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  rxd_infifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i), .en(rx_en), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_crc(in_crc_err), .in_lerr(in_len_err), .pop(f_pop),
    .out_ent(f_ent), .out_valid(f_valid), .ovf_pulse(in_ovf)
  );

  rxd_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_i), .ring_base(ring_base), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_resume(cmd_resume), .f_ent(f_ent), .f_valid(f_valid),
    .f_pop(f_pop), .in_ovf(in_ovf), .rx_en(rx_en), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .ev_frame_done(ev_frame_done), .ev_buf_unavail(ev_buf_unavail),
    .ev_overflow(ev_overflow), .ev_stopped(ev_stopped)
  );
endmodule

// File: tb/tb_rxd_ring_dma.sv
`timescale 1ns/1ps
module tb_rxd_ring_dma;
  logic        clk, rst_n;
  logic [15:0] ring_base;
  logic        cmd_start, cmd_stop, cmd_resume;
  logic        in_valid, in_last, in_crc_err, in_len_err;
  logic [7:0]  in_data;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        ev_frame_done, ev_buf_unavail, ev_overflow, ev_stopped;
  logic [31:0] mem [256];
  int total, bad, n_frame, n_ovf, n_stop;

  rxd_ring_dma dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we)
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem[mem_addr[9:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
      mem_rdata <= mem[mem_addr[9:2]];
    end
    if (ev_frame_done) n_frame++;
    if (ev_overflow)   n_ovf++;
    if (ev_stopped)    n_stop++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bv(input logic [7:0] seed, input int i);
    return seed + 8'(3 * i);
  endfunction

  function automatic logic [31:0] rd(input int addr);
    return mem[addr[9:2]];
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ring_base = 16'h0; cmd_start = 0; cmd_stop = 0; cmd_resume = 0;
    in_valid = 0; in_data = 0; in_last = 0; in_crc_err = 0; in_len_err = 0;
    mem_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5A5A5A5;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    n_frame = 0; n_ovf = 0; n_stop = 0;
  endtask

  task automatic mk_desc(input int idx, input bit own, input int size, input int nxt);
    mem[idx*4]     = own ? 32'h8000_0000 : 32'h0;
    mem[idx*4 + 1] = 32'(size);
    mem[idx*4 + 2] = 32'(16'h100 + idx * 16'h40);
    mem[idx*4 + 3] = 32'(nxt * 16);
  endtask

  task automatic pulse_start();
    ring_base = 16'h0; cmd_start = 1; cyc(1); cmd_start = 0;
  endtask
  task automatic pulse_stop();
    cmd_stop = 1; cyc(1); cmd_stop = 0;
  endtask
  task automatic pulse_resume();
    cmd_resume = 1; cyc(1); cmd_resume = 0;
  endtask

  task automatic send(input int n, input logic [7:0] seed, input bit crc, input bit lerr, input int gap);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = bv(seed, i); in_last = (i == n - 1);
      in_crc_err = crc & (i == n - 1); in_len_err = lerr & (i == n - 1);
      cyc(1);
      in_valid = 0; in_last = 0; in_crc_err = 0; in_len_err = 0;
      cyc(gap);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 events", {28'h0, ev_frame_done, ev_buf_unavail, ev_overflow, ev_stopped}, 32'h0);
    chk("R1 mem idle", {31'h0, mem_en}, 32'h0);
    cyc(20);
    chk("R1 no frames", n_frame, 0);
    chk("R1 still idle", {30'h0, mem_en, ev_buf_unavail}, 32'h0);
  endtask

  task automatic t_single();
    do_reset();
    mk_desc(0, 1, 16, 1); mk_desc(1, 1, 16, 0);
    pulse_start(); cyc(20);
    send(6, 8'h10, 0, 0, 0); cyc(80);
    chk("R4 status single", rd(16'h000), 32'h0006_0300);
    chk("R3 full word", rd(16'h100), {bv(8'h10,3), bv(8'h10,2), bv(8'h10,1), bv(8'h10,0)});
    chk("R3 partial lanes", rd(16'h104), {16'hA5A5, bv(8'h10,5), bv(8'h10,4)});
    chk("R4 frame pulse", n_frame, 1);
    chk("R2 next desc untouched", rd(16'h010), 32'h8000_0000);
  endtask

  task automatic t_multi();
    do_reset();
    for (int d = 0; d < 4; d++) mk_desc(d, 1, 4, (d + 1) % 4);
    pulse_start(); cyc(20);
    send(10, 8'h40, 0, 0, 2); cyc(100);
    chk("R5 first seg", rd(16'h000), 32'h0000_0200);
    chk("R5 middle seg", rd(16'h010), 32'h0000_0000);
    chk("R5 last seg", rd(16'h020), 32'h000A_0100);
    chk("R5 tail data", rd(16'h180), {16'hA5A5, bv(8'h40,9), bv(8'h40,8)});
    chk("R5 middle data", rd(16'h140), {bv(8'h40,7), bv(8'h40,6), bv(8'h40,5), bv(8'h40,4)});
    chk("R5 one frame", n_frame, 1);
  endtask

  task automatic t_errors();
    do_reset();
    for (int d = 0; d < 4; d++) mk_desc(d, 1, 16, (d + 1) % 4);
    pulse_start(); cyc(20);
    send(5, 8'h01, 1, 0, 0); cyc(60);
    send(4, 8'h02, 0, 1, 0); cyc(60);
    chk("R6 crc error", rd(16'h000), 32'h0005_8302);
    chk("R6 length error", rd(16'h010), 32'h0004_9300);
  endtask

  task automatic t_nobuf();
    do_reset();
    mk_desc(0, 0, 16, 1); mk_desc(1, 0, 16, 0);
    pulse_start(); cyc(20);
    chk("R7 wait raised", {31'h0, ev_buf_unavail}, 1);
    cyc(50);
    chk("R7 wait held", {31'h0, ev_buf_unavail}, 1);
    mem[0] = 32'h8000_0000;
    pulse_resume(); cyc(10);
    chk("R7 resumed", {31'h0, ev_buf_unavail}, 0);
    send(4, 8'h30, 0, 0, 0); cyc(60);
    chk("R7 refetched desc used", rd(16'h000), 32'h0004_0300);
    chk("R7 next unowned waits", {31'h0, ev_buf_unavail}, 1);
  endtask

  task automatic t_overflow();
    do_reset();
    mk_desc(0, 0, 64, 1); mk_desc(1, 0, 64, 0);
    pulse_start(); cyc(20);
    send(30, 8'h50, 0, 0, 0); cyc(10);
    chk("R8 overflow pulse", n_ovf, 1);
    mem[0] = 32'h8000_0000;
    pulse_resume(); cyc(80);
    chk("R8 closing status", rd(16'h000), 32'h0010_8B00);
    chk("R8 kept data", rd(16'h10C), {bv(8'h50,15), bv(8'h50,14), bv(8'h50,13), bv(8'h50,12)});
    chk("R8 nothing past kept", rd(16'h110), 32'hA5A5A5A5);
    chk("R8 frame closed", n_frame, 1);
  endtask

  task automatic t_trunc();
    do_reset();
    mk_desc(0, 1, 4, 1); mk_desc(1, 1, 4, 0);
    pulse_start(); cyc(20);
    send(12, 8'h70, 0, 0, 2); cyc(100);
    chk("R9 opening seg", rd(16'h000), 32'h0000_0200);
    chk("R9 forced close", rd(16'h010), 32'h0008_8900);
    chk("R9 overflow pulse", n_ovf, 1);
    chk("R9 frame pulse", n_frame, 1);
    chk("R9 then waits", {31'h0, ev_buf_unavail}, 1);
    chk("R9 first buffer intact", rd(16'h100), {bv(8'h70,3), bv(8'h70,2), bv(8'h70,1), bv(8'h70,0)});
  endtask

  task automatic t_stop();
    do_reset();
    mk_desc(0, 1, 16, 1); mk_desc(1, 1, 16, 0);
    pulse_start(); cyc(20);
    pulse_stop(); cyc(6);
    chk("R10 stop pulse", n_stop, 1);
    send(4, 8'h90, 0, 0, 0); cyc(40);
    chk("R10 desc untouched", rd(16'h000), 32'h8000_0000);
    chk("R10 no frame", n_frame, 0);
    pulse_start(); cyc(20);
    send(3, 8'hA0, 0, 0, 0); cyc(60);
    chk("R10 ignored bytes absent", rd(16'h000), 32'h0003_0300);
    chk("R10 new data", rd(16'h100), {8'hA5, bv(8'hA0,2), bv(8'hA0,1), bv(8'hA0,0)});
  endtask

  initial begin
    total = 0; bad = 0;
    t_reset();
    t_single();
    t_multi();
    t_errors();
    t_nobuf();
    t_overflow();
    t_trunc();
    t_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule